// File: doc/BRIEF.md
# Triple Match Timer with Interrupts

The block holds three independent 32-bit timers, each with a count, a reload value and two match values, all behind a word-addressed register port. A single control word gives each timer an enable, a clock-source select, a wrap-interrupt enable and, in one variant, a count direction. On every advance a timer steps its count. When the count runs off its end, the timer loads the reload value, which gives periodic operation. Each advance that lands on a match value raises a match event.

A build-time parameter picks one of two variants. The standard variant counts up or down per timer. It collects match and wrap events in sticky status bits, and it drives the interrupt output from the status bits that the mask register does not block. The down-only variant packs the control bits four to a timer and always counts down. It copies the reload value into the count each time software turns a timer's enable from off to on. Its interrupt output is a one-cycle pulse for every match, and for every wrap whose interrupt enable is set. In this variant the status and mask locations are not implemented.

The register port has no back-pressure: a write takes effect on the clock edge where the write strobe is high. Read data is registered on the edge where the read strobe is high and holds until the next read.

Top module: `tmr_triple`

## Requirements
- R1: Byte offsets 16*t+0, +4, +8 and +12 hold timer t's count, reload, match1 and match2 (t = 0..2). The control word is at 0x30. reg_rdata_o shows the addressed register, zero-extended, from the edge where reg_rd_i is high. Unmapped offsets read zero.
- R2: After reset, every count, reload, match, control and status register is zero. The standard mask reads 0x1FF, and irq_o is low.
- R3: In the standard control layout, timer t uses bit 3t for enable, 3t+1 for clock select and 3t+2 for wrap-interrupt enable. Bit 9+t sets its direction: 1 counts up, 0 counts down.
- R4: In the down-only control layout, timer t uses bit 4t for enable, 4t+1 for clock select and 4t+2 for wrap-interrupt enable. All other bits have no effect, and every timer counts down.
- R5: An enabled timer with clock select 0 advances on every clock. With clock select 1 it advances only on clocks where tick_en_i is high. A disabled timer holds its count.
- R6: Counting up, an advance from 0xFFFFFFFF loads the reload value and raises a wrap event. Otherwise it adds one, so a count and reload of 0xFFFFFFFF-(P-1) wrap every P advances.
- R7: Counting down, an advance from zero loads the reload value and raises a wrap event. Otherwise it subtracts one.
- R8: An advance whose new count equals match1 or match2 raises the corresponding match event.
- R9: In the standard variant, status bits 3t, 3t+1 and 3t+2 record timer t's match1, match2 and wrap events. A wrap is recorded only when its interrupt enable is set. Status bits stay set until software changes them. A write to offset 0x34 replaces the status, except that events in the same cycle still set their bits.
- R10: In the standard variant, irq_o is high exactly while some status bit is set whose bit in the mask register (offset 0x38) is zero.
- R11: In the down-only variant, offsets 0x34 and 0x38 read zero and writes to them have no effect.
- R12: In the down-only variant, a control write that changes a timer's enable from 0 to 1 loads that timer's reload value into its count.
- R13: In the down-only variant, irq_o is high for one cycle after each advance that raises a match event, or a wrap event with its interrupt enable set.
- R14: A software write to a count takes priority over an advance or a reload load in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low reset |
| tick_en_i | input | 1 | External tick enable for timers with clock select 1 |
| reg_addr_i | input | 6 | Byte address; bits 1:0 are ignored |
| reg_wdata_i | input | 32 | Write data |
| reg_wr_i | input | 1 | Write strobe |
| reg_rd_i | input | 1 | Read strobe |
| reg_rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Interrupt output |

## Verification
A register write lands on the edge where its strobe is high. A read result appears on reg_rdata_o at that same edge. A count advance, a status bit and the down-only interrupt pulse all appear at the edge of the advancing cycle, and the standard irq_o follows the status and mask registers with no added delay. The bench drives every stimulus for exactly one clock from a falling edge, so each result is sampled at the next falling edge. The external tick is the only stepping source, except in the free-running checks, which count clock edges between two control writes. The down-only pulse is also checked low one cycle later.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef struct packed {
    logic en;
    logic clk_sel;
    logic ie;
    logic up;
  } tmr_cfg_t;

  // Fields inside one timer's 16-byte slot
  localparam int unsigned FLD_CNT = 0;
  localparam int unsigned FLD_RLD = 1;
  localparam int unsigned FLD_M1  = 2;
  localparam int unsigned FLD_M2  = 3;

  // Control bit positions per timer for both layouts
  function automatic int unsigned pos_en(input bit down_only, input int unsigned t);
    return down_only ? 4 * t : 3 * t;
  endfunction
  function automatic int unsigned pos_clk(input bit down_only, input int unsigned t);
    return pos_en(down_only, t) + 1;
  endfunction
  function automatic int unsigned pos_ie(input bit down_only, input int unsigned t);
    return pos_en(down_only, t) + 2;
  endfunction
endpackage

// File: rtl/tmr_ctrl_decode.sv
module tmr_ctrl_decode
  import tmr_pkg::*;
#(
  parameter int unsigned NT        = 3,
  parameter bit          DOWN_ONLY = 1'b0,
  localparam int unsigned CW       = 4 * NT
) (
  input  logic [CW-1:0]           ctrl_i,
  output tmr_cfg_t [NT-1:0]       cfg_o
);
  for (genvar g = 0; g < NT; g++) begin : g_tmr
    localparam int unsigned P_EN  = pos_en(DOWN_ONLY, g);
    localparam int unsigned P_CLK = pos_clk(DOWN_ONLY, g);
    localparam int unsigned P_IE  = pos_ie(DOWN_ONLY, g);
    assign cfg_o[g].en      = ctrl_i[P_EN];
    assign cfg_o[g].clk_sel = ctrl_i[P_CLK];
    assign cfg_o[g].ie      = ctrl_i[P_IE];
    if (DOWN_ONLY) begin : g_down
      assign cfg_o[g].up = 1'b0;
    end else begin : g_updn
      localparam int unsigned P_DIR = 3 * NT + g;
      assign cfg_o[g].up = ctrl_i[P_DIR];
    end
  end
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit #(
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] wdata_i,
  input  logic          wr_cnt_i,
  input  logic          wr_rld_i,
  input  logic          wr_m1_i,
  input  logic          wr_m2_i,
  input  logic          load_i,
  input  logic          adv_i,
  input  logic          up_i,
  output logic [DW-1:0] cnt_o,
  output logic [DW-1:0] rld_o,
  output logic [DW-1:0] m1_o,
  output logic [DW-1:0] m2_o,
  output logic          ev_m1_o,
  output logic          ev_m2_o,
  output logic          ev_wrap_o
);
  logic [DW-1:0] cnt_q, rld_q, m1_q, m2_q, step;
  logic          at_end, stepping;

  always_comb begin
    at_end   = up_i ? (cnt_q == '1) : (cnt_q == '0);
    if (at_end)    step = rld_q;
    else if (up_i) step = cnt_q + DW'(1);
    else           step = cnt_q - DW'(1);
    stepping = adv_i && !wr_cnt_i && !load_i;
  end

  assign ev_wrap_o = stepping && at_end;
  assign ev_m1_o   = stepping && (step == m1_q);
  assign ev_m2_o   = stepping && (step == m2_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      rld_q <= '0;
      m1_q  <= '0;
      m2_q  <= '0;
    end else begin
      if (wr_cnt_i)      cnt_q <= wdata_i;
      else if (load_i)   cnt_q <= rld_q;
      else if (adv_i)    cnt_q <= step;
      if (wr_rld_i)      rld_q <= wdata_i;
      if (wr_m1_i)       m1_q  <= wdata_i;
      if (wr_m2_i)       m2_q  <= wdata_i;
    end
  end

  assign cnt_o = cnt_q;
  assign rld_o = rld_q;
  assign m1_o  = m1_q;
  assign m2_o  = m2_q;

  AST_SW_WRITE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cnt_i |=> (cnt_q == $past(wdata_i))); // R14
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adv_i && !wr_cnt_i && !load_i) |=> $stable(cnt_q)); // R5
  AST_WRAP_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_wrap_o |=> (cnt_q == $past(rld_q))); // R6
  AST_DOWN_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stepping && !up_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - DW'(1))); // R7
endmodule

// File: rtl/tmr_irq.sv
module tmr_irq #(
  parameter int unsigned NT        = 3,
  parameter bit          DOWN_ONLY = 1'b0,
  localparam int unsigned SW       = 3 * NT
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [SW-1:0] ev_i,
  input  logic          sts_wr_i,
  input  logic          msk_wr_i,
  input  logic [SW-1:0] wdata_i,
  output logic [SW-1:0] sts_o,
  output logic [SW-1:0] msk_o,
  output logic          irq_o
);
  if (DOWN_ONLY) begin : g_pulse
    logic irq_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) irq_q <= 1'b0;
      else         irq_q <= |ev_i;
    end
    assign sts_o = '0;
    assign msk_o = '0;
    assign irq_o = irq_q;

    AST_PULSE_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (irq_o && !(|ev_i)) |=> !irq_o); // R13
  end else begin : g_sticky
    logic [SW-1:0] sts_q, msk_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sts_q <= '0;
        msk_q <= '1;
      end else begin
        sts_q <= (sts_wr_i ? wdata_i : sts_q) | ev_i;
        if (msk_wr_i) msk_q <= wdata_i;
      end
    end
    assign sts_o = sts_q;
    assign msk_o = msk_q;
    assign irq_o = |(sts_q & ~msk_q);

    AST_STS_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !sts_wr_i |=> ((sts_q & $past(sts_q)) == $past(sts_q))); // R9
    AST_EVENT_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ev_i != '0) |=> ((sts_q & $past(ev_i)) == $past(ev_i))); // R9
    AST_FULL_MASK_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (msk_q == '1) |-> !irq_o); // R10
  end
endmodule

// File: rtl/tmr_triple.sv
module tmr_triple
  import tmr_pkg::*;
#(
  parameter int unsigned NT        = 3,
  parameter int unsigned DW        = 32,
  parameter int unsigned AW        = 6,
  parameter bit          DOWN_ONLY = 1'b0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_en_i,
  input  logic [AW-1:0] reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  input  logic          reg_wr_i,
  input  logic          reg_rd_i,
  output logic [DW-1:0] reg_rdata_o,
  output logic          irq_o
);
  localparam int unsigned CW       = 4 * NT;
  localparam int unsigned SW       = 3 * NT;
  localparam int unsigned WIW      = AW - 2;
  localparam int unsigned CTRL_IDX = 4 * NT;
  localparam int unsigned STS_IDX  = CTRL_IDX + 1;
  localparam int unsigned MSK_IDX  = CTRL_IDX + 2;
  localparam logic [WIW-1:0] CTRL_W = CTRL_IDX[WIW-1:0];
  localparam logic [WIW-1:0] STS_W  = STS_IDX[WIW-1:0];
  localparam logic [WIW-1:0] MSK_W  = MSK_IDX[WIW-1:0];

  logic [WIW-1:0] widx;
  logic [CW-1:0]  ctrl_q;
  logic           ctrl_wr, sts_wr, msk_wr;
  tmr_cfg_t [NT-1:0] cfg, cfg_new;
  logic [SW-1:0]  ev, sts, msk;
  logic [DW-1:0]  cnt [NT];
  logic [DW-1:0]  rld [NT];
  logic [DW-1:0]  rd_part [NT];
  logic [NT-1:0]  ld;
  logic [DW-1:0]  rd_mux, rdata_q;

  assign widx    = reg_addr_i[AW-1:2];
  assign ctrl_wr = reg_wr_i && (widx == CTRL_W);
  assign sts_wr  = reg_wr_i && (widx == STS_W) && !DOWN_ONLY;
  assign msk_wr  = reg_wr_i && (widx == MSK_W) && !DOWN_ONLY;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= '0;
    else if (ctrl_wr) ctrl_q <= reg_wdata_i[CW-1:0];
  end

  tmr_ctrl_decode #(.NT(NT), .DOWN_ONLY(DOWN_ONLY)) u_dec_cur (
    .ctrl_i (ctrl_q),
    .cfg_o  (cfg)
  );
  tmr_ctrl_decode #(.NT(NT), .DOWN_ONLY(DOWN_ONLY)) u_dec_new (
    .ctrl_i (reg_wdata_i[CW-1:0]),
    .cfg_o  (cfg_new)
  );

  for (genvar g = 0; g < NT; g++) begin : g_tmr
    localparam int unsigned SL   = 4 * g;
    localparam int unsigned I_C  = SL + FLD_CNT;
    localparam int unsigned I_R  = SL + FLD_RLD;
    localparam int unsigned I_1  = SL + FLD_M1;
    localparam int unsigned I_2  = SL + FLD_M2;
    localparam logic [WIW-1:0] W_C = I_C[WIW-1:0];
    localparam logic [WIW-1:0] W_R = I_R[WIW-1:0];
    localparam logic [WIW-1:0] W_1 = I_1[WIW-1:0];
    localparam logic [WIW-1:0] W_2 = I_2[WIW-1:0];
    logic adv, ev_m1, ev_m2, ev_wrap;
    logic [DW-1:0] m1, m2;

    assign adv   = cfg[g].en && (!cfg[g].clk_sel || tick_en_i);
    assign ld[g] = DOWN_ONLY && ctrl_wr && !cfg[g].en && cfg_new[g].en;

    tmr_unit #(.DW(DW)) u_unit (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wdata_i   (reg_wdata_i),
      .wr_cnt_i  (reg_wr_i && (widx == W_C)),
      .wr_rld_i  (reg_wr_i && (widx == W_R)),
      .wr_m1_i   (reg_wr_i && (widx == W_1)),
      .wr_m2_i   (reg_wr_i && (widx == W_2)),
      .load_i    (ld[g]),
      .adv_i     (adv),
      .up_i      (cfg[g].up),
      .cnt_o     (cnt[g]),
      .rld_o     (rld[g]),
      .m1_o      (m1),
      .m2_o      (m2),
      .ev_m1_o   (ev_m1),
      .ev_m2_o   (ev_m2),
      .ev_wrap_o (ev_wrap)
    );

    assign ev[3*g]   = ev_m1;
    assign ev[3*g+1] = ev_m2;
    assign ev[3*g+2] = ev_wrap && cfg[g].ie;

    always_comb begin
      if      (widx == W_C) rd_part[g] = cnt[g];
      else if (widx == W_R) rd_part[g] = rld[g];
      else if (widx == W_1) rd_part[g] = m1;
      else if (widx == W_2) rd_part[g] = m2;
      else                  rd_part[g] = '0;
    end

    if (DOWN_ONLY) begin : g_ld_chk
      AST_ENABLE_LOADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ld[g] |=> (cnt[g] == $past(rld[g]))); // R12
    end
  end

  tmr_irq #(.NT(NT), .DOWN_ONLY(DOWN_ONLY)) u_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ev_i     (ev),
    .sts_wr_i (sts_wr),
    .msk_wr_i (msk_wr),
    .wdata_i  (reg_wdata_i[SW-1:0]),
    .sts_o    (sts),
    .msk_o    (msk),
    .irq_o    (irq_o)
  );

  always_comb begin
    rd_mux = '0;
    for (int t = 0; t < NT; t++) rd_mux = rd_mux | rd_part[t];
    if (widx == CTRL_W) rd_mux = {{(DW-CW){1'b0}}, ctrl_q};
    if (widx == STS_W)  rd_mux = {{(DW-SW){1'b0}}, sts};
    if (widx == MSK_W)  rd_mux = {{(DW-SW){1'b0}}, msk};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rdata_q <= '0;
    else if (reg_rd_i) rdata_q <= rd_mux;
  end
  assign reg_rdata_o = rdata_q;

  AST_CTRL_READBACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rd_i && widx == CTRL_W && !ctrl_wr) |=>
      (reg_rdata_o == {{(DW-CW){1'b0}}, $past(ctrl_q)})); // R1

  if (DOWN_ONLY) begin : g_noreg_chk
    AST_ABSENT_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (reg_rd_i && (widx == STS_W || widx == MSK_W)) |=> (reg_rdata_o == '0)); // R11
  end
endmodule

// File: tb/tmr_triple_tb.sv
module tmr_triple_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        wr_s = 1'b0, rd_s = 1'b0, wr_d = 1'b0, rd_d = 1'b0;
  logic [31:0] rdata_s, rdata_d;
  logic        irq_s, irq_d;
  int          checks = 0;
  int          errors = 0;

  always #5 clk = ~clk;

  tmr_triple #(.DOWN_ONLY(1'b0)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_en_i(tick), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_wr_i(wr_s), .reg_rd_i(rd_s),
    .reg_rdata_o(rdata_s), .irq_o(irq_s)
  );
  tmr_triple #(.DOWN_ONLY(1'b1)) dut_d_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_en_i(tick), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_wr_i(wr_d), .reg_rd_i(rd_d),
    .reg_rdata_o(rdata_d), .irq_o(irq_d)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic wr(input bit d, input logic [5:0] a, input logic [31:0] v);
    addr = a; wdata = v;
    if (d) wr_d = 1'b1; else wr_s = 1'b1;
    @(posedge clk); @(negedge clk);
    wr_d = 1'b0; wr_s = 1'b0;
  endtask

  task automatic rd(input bit d, input logic [5:0] a, output logic [31:0] v);
    addr = a;
    if (d) rd_d = 1'b1; else rd_s = 1'b1;
    @(posedge clk); @(negedge clk);
    rd_d = 1'b0; rd_s = 1'b0;
    v = d ? rdata_d : rdata_s;
  endtask

  task automatic rd_chk(input bit d, input logic [5:0] a, input logic [31:0] exp, input string req);
    logic [31:0] v;
    rd(d, a, v);
    check(req, v, exp);
  endtask

  task automatic tick1();
    tick = 1'b1;
    @(posedge clk); @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic t_reset();
    rd_chk(0, 6'h30, 32'h0, "R2 ctrl");
    rd_chk(0, 6'h38, 32'h1FF, "R2 mask");
    rd_chk(0, 6'h34, 32'h0, "R2 status");
    rd_chk(0, 6'h00, 32'h0, "R2 count");
    check("R2 irq std", {31'b0, irq_s}, 32'h0);
    check("R2 irq down", {31'b0, irq_d}, 32'h0);
  endtask

  task automatic t_regmap();
    wr(0, 6'h28, 32'hA5A5_0001);
    wr(0, 6'h2C, 32'h5A5A_0002);
    wr(0, 6'h14, 32'h0000_1234);
    rd_chk(0, 6'h28, 32'hA5A5_0001, "R1 t3 match1");
    rd_chk(0, 6'h2C, 32'h5A5A_0002, "R1 t3 match2");
    rd_chk(0, 6'h14, 32'h0000_1234, "R1 t2 reload");
    rd_chk(0, 6'h3C, 32'h0, "R1 unmapped");
  endtask

  task automatic t_up_periodic();
    wr(0, 6'h00, 32'hFFFF_FFFC);
    wr(0, 6'h04, 32'hFFFF_FFFC);
    wr(0, 6'h08, 32'h100);
    wr(0, 6'h0C, 32'h100);
    wr(0, 6'h38, 32'h1FB);
    wr(0, 6'h30, 32'h207);   // en, tick clock, ie, up
    repeat (3) tick1();
    check("R10 irq before wrap", {31'b0, irq_s}, 32'h0);
    rd_chk(0, 6'h00, 32'hFFFF_FFFF, "R6 count before wrap");
    tick1();
    check("R10 irq on wrap", {31'b0, irq_s}, 32'h1);
    rd_chk(0, 6'h00, 32'hFFFF_FFFC, "R6 wrap reload");
    rd_chk(0, 6'h34, 32'h4, "R9 wrap status bit");
    wr(0, 6'h38, 32'h1FF);
    check("R10 masked", {31'b0, irq_s}, 32'h0);
    wr(0, 6'h34, 32'h0);
    rd_chk(0, 6'h34, 32'h0, "R9 status cleared");
    wr(0, 6'h30, 32'h203);   // ie off
    repeat (4) tick1();
    rd_chk(0, 6'h34, 32'h0, "R9 wrap without ie");
    wr(0, 6'h30, 32'h003);   // direction bit 0 = down
    tick1();
    rd_chk(0, 6'h00, 32'hFFFF_FFFB, "R3 down direction");
    wr(0, 6'h30, 32'h0);
  endtask

  task automatic t_match();
    wr(0, 6'h00, 32'd10);
    wr(0, 6'h08, 32'd12);
    wr(0, 6'h34, 32'h0);
    wr(0, 6'h38, 32'h1FE);
    wr(0, 6'h30, 32'h203);
    tick1();
    check("R8 no match yet", {31'b0, irq_s}, 32'h0);
    tick1();
    check("R8 match irq", {31'b0, irq_s}, 32'h1);
    rd_chk(0, 6'h34, 32'h1, "R8 match1 status");
    tick1();
    rd_chk(0, 6'h34, 32'h1, "R9 sticky");
    wr(0, 6'h30, 32'h0);
    wr(0, 6'h34, 32'h0);
    check("R10 irq after clear", {31'b0, irq_s}, 32'h0);
  endtask

  task automatic t_gating();
    wr(0, 6'h10, 32'h0);
    wr(0, 6'h30, 32'h408);   // timer 2 en, every clock, up
    repeat (3) @(negedge clk);
    wr(0, 6'h30, 32'h0);
    rd_chk(0, 6'h10, 32'd4, "R5 free running");
    wr(0, 6'h30, 32'h418);   // tick clock
    repeat (3) @(negedge clk);
    rd_chk(0, 6'h10, 32'd4, "R5 no tick hold");
    tick1();
    rd_chk(0, 6'h10, 32'd5, "R5 tick advance");
    wr(0, 6'h30, 32'h408);
    wr(0, 6'h10, 32'd100);
    rd_chk(0, 6'h10, 32'd100, "R14 write beats advance");
    wr(0, 6'h30, 32'h0);
  endtask

  task automatic t_down_only();
    wr(1, 6'h04, 32'd5);
    wr(1, 6'h08, 32'd3);
    wr(1, 6'h0C, 32'hFFFF);
    wr(1, 6'h30, 32'h3);
    rd_chk(1, 6'h00, 32'd5, "R12 enable loads");
    tick1();
    check("R13 quiet", {31'b0, irq_d}, 32'h0);
    tick1();
    check("R13 match pulse", {31'b0, irq_d}, 32'h1);
    @(negedge clk);
    check("R13 pulse ends", {31'b0, irq_d}, 32'h0);
    repeat (3) tick1();
    tick1();
    check("R13 wrap no ie", {31'b0, irq_d}, 32'h0);
    rd_chk(1, 6'h00, 32'd5, "R7 down wrap reload");
    wr(1, 6'h30, 32'h7);
    wr(1, 6'h00, 32'd0);
    tick1();
    check("R7 wrap irq with ie", {31'b0, irq_d}, 32'h1);
    wr(1, 6'h00, 32'd9);
    wr(1, 6'h30, 32'h0);
    wr(1, 6'h30, 32'h7);
    rd_chk(1, 6'h00, 32'd5, "R12 re-enable loads");
    wr(1, 6'h30, 32'h0);
    wr(1, 6'h24, 32'd2);
    wr(1, 6'h28, 32'h100);
    wr(1, 6'h2C, 32'h100);
    wr(1, 6'h30, 32'hF00);   // timer 3 en/clk/ie plus a spare bit
    rd_chk(1, 6'h20, 32'd2, "R4 t3 enable bit 8");
    tick1();
    tick1();
    check("R4 t3 no irq at zero", {31'b0, irq_d}, 32'h0);
    tick1();
    check("R4 t3 wrap irq", {31'b0, irq_d}, 32'h1);
    rd_chk(1, 6'h20, 32'd2, "R4 t3 counts down");
    wr(1, 6'h34, 32'h1FF);
    wr(1, 6'h38, 32'h0);
    rd_chk(1, 6'h34, 32'h0, "R11 status absent");
    rd_chk(1, 6'h38, 32'h0, "R11 mask absent");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regmap();
    t_up_periodic();
    t_match();
    t_gating();
    t_down_only();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule